// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This block holds the interrupt status word of a USB host controller and turns it into interrupt requests. Event sources elsewhere in the controller (frame counter, root hub, list processing) each deliver a single-cycle pulse. A pulse latches its status flag. The flag stays set until software writes a one to its position through a small register port. Hardware never clears a flag, and software can never set one.

A companion enable word holds one enable per event and a global master enable. The normal interrupt line is raised when at least one latched flag is enabled and the master enable is on. The ownership-change flag is kept apart from this line. It drives a dedicated management interrupt output, gated only by its own enable. The build parameter `HAS_SMI` removes that path: the flag is then tied to zero and the management output is held low.

The register port is a flat word interface. A write lands on the rising clock edge when `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `hc_intr_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status flag and every enable bit becomes 0, so that both words read 0 and `irq` and `smi` are 0 after that edge.
- R2: A one on `evt_pulse[i]` at a clock edge sets status bit i (LSB-0 numbering) after that edge. The flags map as follows: 0 scheduling overrun, 1 done-queue writeback, 2 start of frame, 3 resume detected, 4 unrecoverable error, 5 frame number overflow, 6 root hub status change. The bit then holds until software clears it.
- R3: A write to `STATUS_ADDR` (default 0) clears each status bit whose `bus_wdata` bit is 1. Data bits that are 0 leave their flags unchanged, and no write ever sets a status bit.
- R4: When an event pulse and a software clear hit the same bit at the same edge, the bit ends up set.
- R5: Status bits 7 to 29 and bit 31 always read 0.
- R6: The enable word sits at `ENABLE_ADDR` (default 1). Bits 0 to 6 enable the matching events, bit 30 enables ownership change and bit 31 is the master enable. `irq` is 1 exactly when bit 31 is set and some status bit in 0..6 is set together with its enable.
- R7: With `HAS_SMI`=1, a pulse on `oc_req` sets status bit 30. `smi` is 1 exactly when status bit 30 and enable bit 30 are both set, whatever the master enable. Bit 30 never contributes to `irq`.
- R8: With `HAS_SMI`=0, status bit 30 and enable bit 30 always read 0, `smi` is always 0, and `oc_req` has no effect.
- R9: The enable word is read/write. Only bits 0 to 6, 31 and (when `HAS_SMI`=1) 30 are stored; every other bit reads 0.
- R10: A write to any address other than the two register addresses changes no state, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 7 | Single-cycle event pulses, one per status flag 0..6 |
| oc_req | input | 1 | Ownership-change request pulse |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Normal interrupt request |
| smi | output | 1 | Management interrupt for ownership change |

## Verification
The bench concentrates on three edge cases:
- A pulse and a clearing write on the same flag in one cycle. A clear-wins design would drop the event.
- Writes of zeros, and writes of all ones to already-clear flags. A design that wrote the data through instead of clearing would set flags or wipe unrelated ones.
- The master enable switched off while enabled flags are pending. This exposes an interrupt line that ignores the master.

Ownership change is driven with the master off, to show that `smi` bypasses the master and that bit 30 never reaches `irq`. A second instance built without the management path checks that the tied-off bit stays at zero. Writes to unused addresses must leave both words untouched.

// File: rtl/hcis_pkg.sv
// Package: shared constants for the interrupt status unit.
// Assumes a fixed 32-bit register word. Bit positions are part of the
// software-visible map and must not move.
package hcis_pkg;
    localparam int REG_W   = 32;
    localparam int EVT_N   = 7;
    localparam int OC_BIT  = 30;
    localparam int MIE_BIT = 31;

    // Event flag positions (LSB-0)
    typedef enum int unsigned {
        EV_SCHED_OVERRUN = 0,
        EV_WB_DONE_HEAD  = 1,
        EV_FRAME_START   = 2,
        EV_RESUME        = 3,
        EV_FATAL_ERR     = 4,
        EV_FRNUM_WRAP    = 5,
        EV_ROOTHUB_CHG   = 6
    } evt_idx_e;

    localparam logic [REG_W-1:0] EVT_MASK = {{(REG_W-EVT_N){1'b0}}, {EVT_N{1'b1}}};

    // Implemented status bits for a given build
    function automatic logic [REG_W-1:0] status_mask(input bit has_smi);
        logic [REG_W-1:0] m;
        m = EVT_MASK;
        if (has_smi) m[OC_BIT] = 1'b1;
        return m;
    endfunction

    // Implemented enable bits: status bits plus master enable
    function automatic logic [REG_W-1:0] enable_mask(input bit has_smi);
        logic [REG_W-1:0] m;
        m = status_mask(has_smi);
        m[MIE_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/hcis_sticky_bank.sv
// Module: bank of set-by-hardware, clear-by-software status flags.
// Each implemented bit sets on set_vec and clears on clr_vec; set wins.
// Bits outside IMPL_MASK are constant 0 and their inputs are ignored.
module hcis_sticky_bank #(
    parameter int              W         = 32,
    parameter logic [W-1:0]    IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_flop
            // Purpose: latch one flag; a set in the same cycle beats a clear
            always_ff @(posedge clk) begin
                if (!rst_n)          flags[i] <= 1'b0;
                else if (set_vec[i]) flags[i] <= 1'b1;
                else if (clr_vec[i]) flags[i] <= 1'b0;
            end
        end else begin : g_tie
            logic unused_in;
            assign unused_in = set_vec[i] ^ clr_vec[i];
            assign flags[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/hcis_enable_reg.sv
// Module: plain read/write enable word.
// Only bits in IMPL_MASK are stored; the rest read as 0.
module hcis_enable_reg #(
    parameter int           W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Purpose: load masked write data, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata & IMPL_MASK;
    end
endmodule

// File: rtl/hcis_reg_port.sv
// Module: address decode for the two-word register port.
// Produces the write-one-to-clear vector, the enable write strobe and
// the combinational read mux. Unknown addresses read 0 and ignore writes.
module hcis_reg_port #(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 0,
    parameter int ENABLE_ADDR = 1
) (
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [hcis_pkg::REG_W-1:0] bus_wdata,
    input  logic [hcis_pkg::REG_W-1:0] sts,
    input  logic [hcis_pkg::REG_W-1:0] en,
    output logic [hcis_pkg::REG_W-1:0] clr_vec,
    output logic                     en_wr,
    output logic [hcis_pkg::REG_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ENABLE_ADDR);

    logic hit_sts, hit_en;

    // Purpose: decode the address into register hits
    always_comb begin
        hit_sts = (bus_addr == A_STS);
        hit_en  = (bus_addr == A_EN);
    end

    // Purpose: derive write side effects
    always_comb begin
        clr_vec = (bus_wr && hit_sts) ? bus_wdata : '0;
        en_wr   = bus_wr && hit_en;
    end

    // Purpose: select read data
    always_comb begin
        if (hit_sts)     bus_rdata = sts;
        else if (hit_en) bus_rdata = en;
        else             bus_rdata = '0;
    end
endmodule

// File: rtl/hcis_irq_gen.sv
// Module: interrupt request generation.
// irq: any enabled event flag, gated by the master enable.
// smi: ownership-change flag with its own enable, master ignored.
module hcis_irq_gen #(
    parameter bit HAS_SMI = 1'b1
) (
    input  logic [hcis_pkg::REG_W-1:0] sts,
    input  logic [hcis_pkg::REG_W-1:0] en,
    output logic                       irq,
    output logic                       smi
);
    import hcis_pkg::*;

    logic [EVT_N-1:0] pending;

    // Purpose: find enabled event flags and gate them with the master
    always_comb begin
        pending = sts[EVT_N-1:0] & en[EVT_N-1:0];
        irq     = en[MIE_BIT] & (|pending);
    end

    if (HAS_SMI) begin : g_smi
        assign smi = sts[OC_BIT] & en[OC_BIT];
    end else begin : g_nosmi
        logic unused_oc;
        assign unused_oc = sts[OC_BIT] ^ en[OC_BIT];
        assign smi       = 1'b0;
    end

    logic unused_bits;
    assign unused_bits = ^{sts[REG_W-1:OC_BIT+1], sts[OC_BIT-1:EVT_N], en[OC_BIT-1:EVT_N]};
endmodule

// File: rtl/hc_intr_status.sv
// Module: top of the host controller interrupt status unit.
// Assumes event pulses and oc_req are synchronous single-cycle pulses.
// Composes the sticky status bank, enable word, register port and IRQ logic.
module hc_intr_status #(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 0,
    parameter int ENABLE_ADDR = 1,
    parameter bit HAS_SMI     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        evt_pulse,
    input  logic              oc_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              smi
);
    import hcis_pkg::*;

    localparam logic [REG_W-1:0] STS_MASK = status_mask(HAS_SMI);
    localparam logic [REG_W-1:0] EN_MASK  = enable_mask(HAS_SMI);

    logic [REG_W-1:0] sts_q, en_q, set_vec, clr_vec;
    logic             en_wr;

    // Purpose: place hardware event sources at their status positions
    always_comb begin
        set_vec               = '0;
        set_vec[EVT_N-1:0]    = evt_pulse;
        set_vec[OC_BIT]       = oc_req;
    end

    hcis_sticky_bank #(.W(REG_W), .IMPL_MASK(STS_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(sts_q)
    );

    hcis_enable_reg #(.W(REG_W), .IMPL_MASK(EN_MASK)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(en_wr), .wdata(bus_wdata), .q(en_q)
    );

    hcis_reg_port #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)) u_port (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .sts(sts_q), .en(en_q), .clr_vec(clr_vec), .en_wr(en_wr), .bus_rdata(bus_rdata)
    );

    hcis_irq_gen #(.HAS_SMI(HAS_SMI)) u_irq (
        .sts(sts_q), .en(en_q), .irq(irq), .smi(smi)
    );
endmodule

// File: rtl/hc_intr_status_chk.sv
// Checker: temporal properties of the interrupt status unit, bound to the top.
module hc_intr_status_chk #(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 0,
    parameter int ENABLE_ADDR = 1,
    parameter bit HAS_SMI     = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [6:0]        evt_pulse,
    input logic              oc_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              smi,
    input logic [31:0]       sts,
    input logic [31:0]       en
);
    import hcis_pkg::*;

    localparam logic [31:0]       RSVD_MASK = ~(EVT_MASK | (32'h1 << OC_BIT));
    localparam logic [31:0]       EN_MASK   = enable_mask(HAS_SMI);
    localparam logic [ADDR_W-1:0] A_STS     = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_EN      = ADDR_W'(ENABLE_ADDR);

    logic [31:0] hw_set;
    always_comb begin
        hw_set          = '0;
        hw_set[6:0]     = evt_pulse;
        hw_set[OC_BIT]  = oc_req & HAS_SMI;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sts == '0 && en == '0));

    // Also covers R4: the set holds even with a clearing write in the same cycle
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((sts[6:0] & $past(evt_pulse)) == $past(evt_pulse)));

    assert_hw_never_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_STS) |=> ((sts & $past(sts)) == $past(sts)));

    assert_sw_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sts & ~$past(sts) & ~$past(hw_set)) == '0));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STS) |-> ((bus_rdata & RSVD_MASK) == '0));

    assert_irq_needs_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en[MIE_BIT]);

    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((sts[6:0] & en[6:0]) != '0));

    assert_smi_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> (sts[OC_BIT] && en[OC_BIT]));

    if (!HAS_SMI) begin : g_tied
        assert_smi_tied_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |-> (!smi && !sts[OC_BIT] && !en[OC_BIT]));
    end

    assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN) |=> (en == ($past(bus_wdata) & EN_MASK)));

    assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_STS && bus_addr != A_EN) |-> (bus_rdata == '0));
endmodule

bind hc_intr_status hc_intr_status_chk #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR), .HAS_SMI(HAS_SMI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .oc_req(oc_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .smi(smi), .sts(sts_q), .en(en_q)
);

// File: tb/hc_intr_status_tb.sv
`timescale 1ns/1ps
module hc_intr_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_pulse = '0;
    logic        oc_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, smi_a, irq_b, smi_b;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference state: a = full build, b = build without management path
    logic [31:0] ms_a = '0, me_a = '0, ms_b = '0, me_b = '0;
    localparam logic [31:0] SMASK_A = 32'h4000_007F;
    localparam logic [31:0] SMASK_B = 32'h0000_007F;
    localparam logic [31:0] EMASK_A = 32'hC000_007F;
    localparam logic [31:0] EMASK_B = 32'h8000_007F;

    always #2.5 clk = ~clk;

    hc_intr_status #(.HAS_SMI(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .oc_req(oc_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a), .smi(smi_a));

    hc_intr_status #(.HAS_SMI(1'b0)) u_dut_nosmi (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .oc_req(oc_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b), .smi(smi_b));

    // Reference model update on each edge
    always @(posedge clk) begin
        logic [31:0] setv, clr;
        if (!rst_n) begin
            ms_a = '0; me_a = '0; ms_b = '0; me_b = '0;
        end else begin
            setv = {1'b0, oc_req, 23'd0, evt_pulse};
            clr  = (bus_wr && bus_addr == 4'd0) ? bus_wdata : 32'd0;
            ms_a = ((ms_a & ~clr) | setv) & SMASK_A;
            ms_b = ((ms_b & ~clr) | setv) & SMASK_B;
            if (bus_wr && bus_addr == 4'd1) begin
                me_a = bus_wdata & EMASK_A;
                me_b = bus_wdata & EMASK_B;
            end
        end
    end

    function automatic logic [31:0] rd_exp(logic [31:0] s, logic [31:0] e);
        if (bus_addr == 4'd0) return s;
        if (bus_addr == 4'd1) return e;
        return 32'd0;
    endfunction

    function automatic logic irq_exp(logic [31:0] s, logic [31:0] e);
        return e[31] && ((s[6:0] & e[6:0]) != 7'd0);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs of both instances against the model
    task automatic compare();
        chk(tag,  "rdata",       rdata_a, rd_exp(ms_a, me_a));
        chk("R6", "irq",         {31'd0, irq_a}, {31'd0, irq_exp(ms_a, me_a)});
        chk("R7", "smi",         {31'd0, smi_a}, {31'd0, ms_a[30] & me_a[30]});
        chk("R8", "rdata_nosmi", rdata_b, rd_exp(ms_b, me_b));
        chk("R8", "irq_nosmi",   {31'd0, irq_b}, {31'd0, irq_exp(ms_b, me_b)});
        chk("R8", "smi_nosmi",   {31'd0, smi_b}, 32'd0);
    endtask

    task automatic step(logic [6:0] e, logic o, logic w, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        compare();
        evt_pulse = e; oc_req = o; bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(logic [3:0] a);
        step(7'd0, 1'b0, 1'b0, a, 32'd0);
    endtask

    initial begin
        // R1: reset state of both words and outputs
        tag = "R1";
        step(7'h7F, 1'b1, 1'b1, 4'd0, 32'h0);
        idle(4'd1); idle(4'd0);
        @(negedge clk); rst_n = 1'b1;
        idle(4'd1); idle(4'd0);

        // R2: each event alone sets its own flag
        tag = "R2";
        for (int i = 0; i < 7; i++) begin
            step(7'(1 << i), 1'b0, 1'b0, 4'd0, 32'd0);
            idle(4'd0);
        end
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF);
        idle(4'd0);

        // R3: selective clear, zero write, all-ones write cannot set
        tag = "R3";
        step(7'b0010101, 1'b0, 1'b0, 4'd0, 32'd0);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'h0000_0004);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'h0000_0000);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF);
        idle(4'd0);

        // R4: set and clear on the same bit in one cycle
        tag = "R4";
        step(7'b0001000, 1'b0, 1'b0, 4'd0, 32'd0);
        step(7'b0001000, 1'b0, 1'b1, 4'd0, 32'h0000_0008);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'h0000_0008);
        idle(4'd0);

        // R5/R9: enable word masks unimplemented bits; status reserved bits read 0
        tag = "R9";
        step(7'd0, 1'b0, 1'b1, 4'd1, 32'hFFFF_FFFF);
        idle(4'd1);
        tag = "R5";
        step(7'h7F, 1'b1, 1'b0, 4'd0, 32'd0);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF);

        // R6: master off suppresses irq, on releases it, clearing drops it
        tag = "R6";
        step(7'd0, 1'b0, 1'b1, 4'd1, 32'h0000_007F);
        step(7'b0000010, 1'b0, 1'b0, 4'd0, 32'd0);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd1, 32'h8000_0001);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd1, 32'h8000_0002);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'h0000_0002);
        idle(4'd0);

        // R7: ownership change reaches smi only, master off
        tag = "R7";
        step(7'd0, 1'b0, 1'b1, 4'd1, 32'h4000_007F);
        step(7'd0, 1'b1, 1'b0, 4'd0, 32'd0);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd1, 32'hC000_007F);
        idle(4'd0);
        step(7'd0, 1'b0, 1'b1, 4'd0, 32'h4000_0000);
        idle(4'd0);

        // R10: other addresses ignore writes and read 0
        tag = "R10";
        step(7'd0, 1'b0, 1'b1, 4'd2, 32'hFFFF_FFFF);
        step(7'd0, 1'b0, 1'b1, 4'd15, 32'hFFFF_FFFF);
        idle(4'd3); idle(4'd0); idle(4'd1);

        // R2/R3/R4 mixed traffic
        tag = "R2";
        for (int n = 0; n < 600; n++) begin
            logic [6:0] e;
            e = 7'($urandom) & 7'($urandom) & 7'($urandom);
            step(e, ($urandom % 8) == 0, ($urandom % 3) == 0, 4'($urandom % 4), $urandom);
        end
        idle(4'd0); idle(4'd1);
        @(negedge clk); compare();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule